// File: doc/BRIEF.md
# Staged PLL Control Register Block

This block holds the clock-generator settings for a chip, plus a pair of random-number registers, behind a simple register-write request port. Software writes a new PLL setting into a staging copy at any time. The setting takes effect in the live copy, which drives the PLL dividers, only when the PLL reset input goes from low to high. A new divider setup therefore never reaches a running PLL in the middle of operation.

Two optional features apply at the commit. First, a bypass configuration can replace the second and fourth divider fields with substitute values. Second, a one-bit mode output reports test mode whenever either of the two test-mode bits in the live word is set.

Requests arrive as a valid/ready beat. The block never applies back-pressure: `req_ready` is high in every cycle out of reset, so each valid beat is taken in the cycle it is presented. A beat presented during reset is dropped. The random-number registers are written directly.

Top module: `pll_cfg_stage`

## Requirements
- R1: Out of reset, both random-number registers read 0, and both the staging and live PLL words equal the parameter `PLL_INIT` (default 0x2041). `test_mode` is then 0.
- R2: A write beat to the PLL address (`ADDR_PLL`, default 0x00) loads `req_data` into the staging word one cycle later and leaves the live word unchanged.
- R3: A write beat to `ADDR_RCTL` (default 0x08) or `ADDR_RDATA` (default 0x10) loads `req_data` into the matching random-number register one cycle later, with no staging.
- R4: A write beat to any other address, and any beat with `req_is_write` low, leaves all four registers unchanged.
- R5: A commit happens when `pll_rst_in` is sampled high at a clock edge after being sampled low at the previous edge. The staging word is then copied into the live word, visible one cycle later. If `pll_rst_in` stays high, or falls, the live word does not change.
- R6: While `bypass_en` is high at a commit edge, live bits [11:6] take `bypass_div2` and live bits [24:18] take `bypass_div4`. All other live bits still come from staging.
- R7: `test_mode` is 1 when live bit 25 or live bit 26 is 1, and 0 otherwise.
- R8: When a PLL-address write and a commit fall in the same edge, the live word takes the staging value held before that write, and the staging word takes the new data.
- R9: `req_ready` is high in every cycle where `rst_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request beat present |
| req_ready | output | 1 | Block accepts the beat (always high out of reset) |
| req_is_write | input | 1 | Beat is a write |
| req_addr | input | ADDR_W | Register address |
| req_data | input | 64 | Write data |
| pll_rst_in | input | 1 | PLL reset; its rise commits staging |
| bypass_en | input | 1 | Apply substitute dividers at commit |
| bypass_div2 | input | 6 | Substitute for live bits [11:6] |
| bypass_div4 | input | 7 | Substitute for live bits [24:18] |
| pll_stage | output | 64 | Staging PLL word |
| pll_live | output | 64 | Live PLL word |
| rng_ctl | output | 64 | Random-number control register |
| rng_data | output | 64 | Random-number data register |
| test_mode | output | 1 | 1 = test mode, 0 = functional mode |

## Verification
Some properties are checked on every cycle:
- the live word holds whenever there is no rising PLL-reset edge;
- a plain commit copies the prior staging word;
- a bypass commit places the substitute divider values;
- non-write beats leave every register untouched;
- a random-number write lands one cycle later;
- ready stays high out of reset.

Other cases only the directed scenarios show:
- the exact reset constants;
- that both test-mode bits independently select test mode;
- that a held-high or falling PLL reset does not re-commit;
- that a same-edge staging write and commit resolve in favour of the old staging value.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;
  localparam int DATA_W    = 64;
  localparam int DIV1_LSB  = 0;
  localparam int DIV1_W    = 6;
  localparam int DIV2_LSB  = 6;
  localparam int DIV2_W    = 6;
  localparam int DIV3_LSB  = 12;
  localparam int DIV3_W    = 6;
  localparam int DIV4_LSB  = 18;
  localparam int DIV4_W    = 7;
  localparam int TSTA_BIT  = 25;
  localparam int TSTB_BIT  = 26;
  localparam int CHG_BIT   = 27;
  localparam int NUM_RNG   = 2;

  typedef enum logic {
    MODE_FUNC = 1'b0,
    MODE_TEST = 1'b1
  } op_mode_e;

  typedef struct packed {
    logic pll;
    logic rctl;
    logic rdata;
  } wr_strobe_t;
endpackage

// File: rtl/pll_cfg_decode.sv
module pll_cfg_decode
  import pll_cfg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_PLL   = 'h00,
  parameter logic [ADDR_W-1:0] ADDR_RCTL  = 'h08,
  parameter logic [ADDR_W-1:0] ADDR_RDATA = 'h10
) (
  input  logic              beat,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] addr,
  output wr_strobe_t        strobe
);
  logic wr_beat;

  assign wr_beat = beat && is_write;

  always_comb begin
    strobe = '0;
    if (wr_beat) begin
      unique case (addr)
        ADDR_PLL:   strobe.pll   = 1'b1;
        ADDR_RCTL:  strobe.rctl  = 1'b1;
        ADDR_RDATA: strobe.rdata = 1'b1;
        default:    strobe       = '0;
      endcase
    end
  end
endmodule

// File: rtl/pll_cfg_commit.sv
module pll_cfg_commit
  import pll_cfg_pkg::*;
#(
  parameter logic [DATA_W-1:0] PLL_INIT = 64'h2041
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stage_we,
  input  logic [DATA_W-1:0] stage_wdata,
  input  logic              pll_rst_in,
  input  logic              bypass_en,
  input  logic [DIV2_W-1:0] bypass_div2,
  input  logic [DIV4_W-1:0] bypass_div4,
  output logic [DATA_W-1:0] stage_q,
  output logic [DATA_W-1:0] live_q
);
  logic              pll_rst_q;
  logic              commit;
  logic [DATA_W-1:0] commit_val;

  assign commit = pll_rst_in && !pll_rst_q;

  // Substitute divider fields when bypass is requested; the rest passes through.
  always_comb begin
    commit_val = stage_q;
    if (bypass_en) begin
      commit_val[DIV2_LSB +: DIV2_W] = bypass_div2;
      commit_val[DIV4_LSB +: DIV4_W] = bypass_div4;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pll_rst_q <= 1'b0;
      stage_q   <= PLL_INIT;
      live_q    <= PLL_INIT;
    end else begin
      pll_rst_q <= pll_rst_in;
      if (stage_we) stage_q <= stage_wdata;
      if (commit)   live_q  <= commit_val;
    end
  end
endmodule

// File: rtl/pll_cfg_rng.sv
module pll_cfg_rng
  import pll_cfg_pkg::*;
#(
  parameter int NREG = NUM_RNG,
  parameter int W    = DATA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREG-1:0] we,
  input  logic [W-1:0]    wdata,
  output logic [NREG*W-1:0] q_flat
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (we[i]) q <= wdata;
    end
    assign q_flat[i*W +: W] = q;
  end
endmodule

// File: rtl/pll_cfg_mode.sv
module pll_cfg_mode
  import pll_cfg_pkg::*;
(
  input  logic [DATA_W-1:0] live,
  output op_mode_e          mode
);
  always_comb begin
    mode = MODE_FUNC;
    if (live[TSTA_BIT] || live[TSTB_BIT]) mode = MODE_TEST;
  end
endmodule

// File: rtl/pll_cfg_stage.sv
module pll_cfg_stage
  import pll_cfg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_PLL   = 'h00,
  parameter logic [ADDR_W-1:0] ADDR_RCTL  = 'h08,
  parameter logic [ADDR_W-1:0] ADDR_RDATA = 'h10,
  parameter logic [63:0]       PLL_INIT   = 64'h2041
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_is_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_data,
  input  logic              pll_rst_in,
  input  logic              bypass_en,
  input  logic [5:0]        bypass_div2,
  input  logic [6:0]        bypass_div4,
  output logic [63:0]       pll_stage,
  output logic [63:0]       pll_live,
  output logic [63:0]       rng_ctl,
  output logic [63:0]       rng_data,
  output logic              test_mode
);
  wr_strobe_t               strobe;
  logic [NUM_RNG*DATA_W-1:0] rng_flat;
  op_mode_e                 mode;
  logic                     beat;

  assign req_ready = rst_n;
  assign beat      = req_valid && req_ready;

  pll_cfg_decode #(
    .ADDR_W(ADDR_W), .ADDR_PLL(ADDR_PLL),
    .ADDR_RCTL(ADDR_RCTL), .ADDR_RDATA(ADDR_RDATA)
  ) u_decode (
    .beat(beat), .is_write(req_is_write), .addr(req_addr), .strobe(strobe)
  );

  pll_cfg_commit #(.PLL_INIT(PLL_INIT)) u_commit (
    .clk(clk), .rst_n(rst_n),
    .stage_we(strobe.pll), .stage_wdata(req_data),
    .pll_rst_in(pll_rst_in), .bypass_en(bypass_en),
    .bypass_div2(bypass_div2), .bypass_div4(bypass_div4),
    .stage_q(pll_stage), .live_q(pll_live)
  );

  pll_cfg_rng #(.NREG(NUM_RNG), .W(DATA_W)) u_rng (
    .clk(clk), .rst_n(rst_n),
    .we({strobe.rdata, strobe.rctl}), .wdata(req_data),
    .q_flat(rng_flat)
  );

  assign rng_ctl  = rng_flat[0 +: DATA_W];
  assign rng_data = rng_flat[DATA_W +: DATA_W];

  pll_cfg_mode u_mode (.live(pll_live), .mode(mode));

  assign test_mode = (mode == MODE_TEST);
endmodule

// File: rtl/pll_cfg_stage_chk.sv
module pll_cfg_stage_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_RCTL = 'h08
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_is_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [63:0]       req_data,
  input logic              pll_rst_in,
  input logic              bypass_en,
  input logic [5:0]        bypass_div2,
  input logic [6:0]        bypass_div4,
  input logic [63:0]       pll_stage,
  input logic [63:0]       pll_live,
  input logic [63:0]       rng_ctl,
  input logic [63:0]       rng_data
);
  logic prev_pll;
  logic rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_pll <= 1'b0;
    else        prev_pll <= pll_rst_in;
  end

  assign rise = pll_rst_in && !prev_pll;

  p_live_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(pll_live));

  p_commit_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !bypass_en) |=> pll_live == $past(pll_stage));

  p_bypass_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && bypass_en) |=> (pll_live[11:6] == $past(bypass_div2))
                         && (pll_live[24:18] == $past(bypass_div4)));

  p_read_no_effect_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_is_write) |=> $stable(pll_stage) && $stable(rng_ctl)
                                     && $stable(rng_data));

  p_rctl_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_write && req_addr == ADDR_RCTL) |=> rng_ctl == $past(req_data));

  p_ready_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready);
endmodule

bind pll_cfg_stage pll_cfg_stage_chk #(.ADDR_W(ADDR_W), .ADDR_RCTL(ADDR_RCTL)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_is_write(req_is_write), .req_addr(req_addr), .req_data(req_data),
  .pll_rst_in(pll_rst_in), .bypass_en(bypass_en), .bypass_div2(bypass_div2),
  .bypass_div4(bypass_div4), .pll_stage(pll_stage), .pll_live(pll_live),
  .rng_ctl(rng_ctl), .rng_data(rng_data)
);

// File: tb/pll_cfg_stage_tb.sv
`timescale 1ns/1ps
module pll_cfg_stage_tb;
  localparam logic [63:0] INIT = 64'h2041;
  localparam logic [7:0]  A_PLL = 8'h00, A_RCTL = 8'h08, A_RDATA = 8'h10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_is_write = 0;
  logic        req_ready;
  logic [7:0]  req_addr = 0;
  logic [63:0] req_data = 0;
  logic        pll_rst_in = 0, bypass_en = 0;
  logic [5:0]  bypass_div2 = 0;
  logic [6:0]  bypass_div4 = 0;
  logic [63:0] pll_stage, pll_live, rng_ctl, rng_data;
  logic        test_mode;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pll_cfg_stage u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_write(req_is_write), .req_addr(req_addr), .req_data(req_data),
    .pll_rst_in(pll_rst_in), .bypass_en(bypass_en), .bypass_div2(bypass_div2),
    .bypass_div4(bypass_div4), .pll_stage(pll_stage), .pll_live(pll_live),
    .rng_ctl(rng_ctl), .rng_data(rng_data), .test_mode(test_mode)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one beat on a falling edge; results are visible at the next falling edge.
  task automatic beat(logic wr, logic [7:0] a, logic [63:0] d);
    req_valid = 1; req_is_write = wr; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 0; req_is_write = 0;
  endtask

  task automatic pulse_pll();
    pll_rst_in = 1;
    @(negedge clk);
    @(negedge clk);
    pll_rst_in = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 stage", pll_stage, INIT);
    check("R1 live", pll_live, INIT);
    check("R1 rctl", rng_ctl, 0);
    check("R1 rdata", rng_data, 0);
    check("R1 mode", {63'b0, test_mode}, 0);
    check("R9 ready", {63'b0, req_ready}, 1);
  endtask

  task automatic t_stage_write();
    beat(1, A_PLL, 64'h0000_0000_0123_4567);
    check("R2 stage", pll_stage, 64'h0000_0000_0123_4567);
    check("R2 live unchanged", pll_live, INIT);
  endtask

  task automatic t_rng_write();
    beat(1, A_RCTL, 64'hAAAA_5555_0000_1111);
    check("R3 rctl", rng_ctl, 64'hAAAA_5555_0000_1111);
    beat(1, A_RDATA, 64'h1234_5678_9ABC_DEF0);
    check("R3 rdata", rng_data, 64'h1234_5678_9ABC_DEF0);
    check("R3 rctl kept", rng_ctl, 64'hAAAA_5555_0000_1111);
  endtask

  task automatic t_ignored();
    beat(1, 8'h18, 64'hDEAD);
    beat(0, A_PLL, 64'hBEEF);
    beat(0, A_RCTL, 64'hBEEF);
    check("R4 stage", pll_stage, 64'h0000_0000_0123_4567);
    check("R4 rctl", rng_ctl, 64'hAAAA_5555_0000_1111);
    check("R4 rdata", rng_data, 64'h1234_5678_9ABC_DEF0);
    check("R4 live", pll_live, INIT);
  endtask

  task automatic t_commit();
    pll_rst_in = 1;
    @(negedge clk);
    check("R5 commit", pll_live, 64'h0000_0000_0123_4567);
    beat(1, A_PLL, 64'h0000_0000_0000_0FFF);
    check("R5 held high no recommit", pll_live, 64'h0000_0000_0123_4567);
    pll_rst_in = 0;
    @(negedge clk);
    @(negedge clk);
    check("R5 fall no commit", pll_live, 64'h0000_0000_0123_4567);
    pulse_pll();
    check("R5 second rise", pll_live, 64'h0000_0000_0000_0FFF);
  endtask

  task automatic t_bypass();
    logic [63:0] exp;
    beat(1, A_PLL, 64'hFFFF_FFFF_F000_0000);
    bypass_en = 1; bypass_div2 = 6'h15; bypass_div4 = 7'h2A;
    pulse_pll();
    exp = 64'hFFFF_FFFF_F000_0000;
    exp[11:6]  = 6'h15;
    exp[24:18] = 7'h2A;
    check("R6 bypass", pll_live, exp);
    bypass_en = 0;
  endtask

  task automatic t_mode();
    beat(1, A_PLL, 64'h1 << 25);
    pulse_pll();
    check("R7 bit25", {63'b0, test_mode}, 1);
    beat(1, A_PLL, 64'h1 << 26);
    pulse_pll();
    check("R7 bit26", {63'b0, test_mode}, 1);
    beat(1, A_PLL, 64'h0F00_0000_01FF_FFFF);
    pulse_pll();
    check("R7 functional", {63'b0, test_mode}, 0);
  endtask

  task automatic t_same_edge();
    beat(1, A_PLL, 64'h0000_0000_0000_0AAA);
    req_valid = 1; req_is_write = 1; req_addr = A_PLL; req_data = 64'h0000_0000_0000_0555;
    pll_rst_in = 1;
    @(negedge clk);
    req_valid = 0; req_is_write = 0;
    check("R8 live old", pll_live, 64'h0000_0000_0000_0AAA);
    check("R8 stage new", pll_stage, 64'h0000_0000_0000_0555);
    pll_rst_in = 0;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_stage_write();
    t_rng_write();
    t_ignored();
    t_commit();
    t_bypass();
    t_mode();
    t_same_edge();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule